// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block is one channel of a DMA controller. A 64-bit configuration descriptor is captured when the channel is armed. It supplies the source and destination pointers, a unit count, a variable-count mode, a trigger code, a transfer mode, a unit size and two pointer step codes. Once armed, the channel waits for its selected trigger. It then copies data over a byte-wide synchronous memory port. Every beat is a read followed by a write, and each request is held until the grant input accepts it.

Four transfer modes decide how much is moved per trigger: one unit, or the whole count. The repeating variants reload the pointers and the count from the captured descriptor and stay armed. In the variable-count modes the first byte read sets the count, and the descriptor length only acts as a ceiling. Each completed count sets a sticky done flag and, if enabled, pulses an interrupt. Writing the arm register with bit 7 set stops the channel at once. The priority field is captured but not used, because arbitration lies outside this block.

Top module: `dma_chan_engine`

## Requirements
- R1: `desc_i` bit fields: [63:48] source pointer, [47:32] destination pointer, [31:19] length, [18:17] source step, [16:15] destination step, [14:13] transfer mode, [12] word unit, [11:7] trigger code, [6:4] count mode, [3] seven-bit count, [2] interrupt enable, [1:0] priority. An arm-register write with bit 0 set and bit 7 clear captures `desc_i` and arms the channel, but only while it is disarmed. Such a write while already armed is ignored.
- R2: Trigger code 0 starts on `sw_req_i`, code 1 on `prev_done_i`, and codes 2..31 on `trig_i[code]`. Pulses on other lines, and any trigger while disarmed, move nothing.
- R3: Transfer mode 0 moves one unit per trigger. After the last unit of the count the channel disarms.
- R4: Transfer mode 1 moves the whole count on one trigger and then disarms. A count of 0 behaves as 1.
- R5: Transfer modes 2 and 3 act like modes 0 and 1. At the end of the count they reload both pointers and the count from the captured descriptor, and the channel stays armed.
- R6: With the word bit set, a unit is two bytes moved low byte first, at pointer and pointer+1. Each byte is a read beat followed by a write beat.
- R7: Step codes: 0 holds the pointer, 1 adds one unit, 2 adds two units, 3 subtracts one unit. A unit is 1 byte, or 2 bytes in word mode. Pointers step after each unit.
- R8: Count modes 1, 2, 3 and 4 set the count to n+1, n, n+2 and n+3. Here n is the first byte read, or its low 7 bits when the seven-bit flag is set. The count is capped at the descriptor length, and the first unit is always moved. Count modes 0 and 5..7 use the length.
- R9: An arm-register write with bit 7 set disarms the channel by the next cycle. It ends any request, sets no done flag, and overrides a same-cycle arm bit or trigger.
- R10: `done_o` is set when a count completes and stays set until `done_clr_i`; a set in the same cycle wins. `irq_o` pulses for one cycle at completion, only when the interrupt enable bit is 1.
- R11: A request holds its address, direction and write data until `mem_gnt_i` is high. Read data is taken the cycle after the read is granted.
- R12: Triggers that arrive while a block is in progress are dropped, not queued.
- R13: After reset the channel is disarmed and idle, with no request, done flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| desc_i | input | 64 | configuration descriptor |
| arm_we_i | input | 1 | arm register write strobe |
| arm_wdata_i | input | 8 | arm register data: bit 0 arm, bit 7 abort |
| sw_req_i | input | 1 | software start pulse |
| prev_done_i | input | 1 | completion pulse of the preceding channel |
| trig_i | input | 32 | event trigger pulses |
| done_clr_i | input | 1 | clears the done flag |
| mem_req_o | output | 1 | memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 16 | byte address |
| mem_wdata_o | output | 8 | write data |
| mem_gnt_i | input | 1 | request accepted this cycle |
| mem_rdata_i | input | 8 | read data, valid the cycle after a granted read |
| armed_o | output | 1 | channel armed |
| busy_o | output | 1 | block in progress |
| done_o | output | 1 | sticky completion flag |
| irq_o | output | 1 | completion interrupt pulse |

## Verification
Two events can land in one cycle: an abort write and the selected trigger. The bench drives both strobes in the same clock cycle on an armed channel. It then expects the channel to be disarmed on the next cycle with no read request, and no write to appear later. A second overlap puts the abort on a channel that is stalled on a withheld grant in the middle of a block. Here no write and no done flag may follow once the grant returns.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned AW     = 16;
  localparam int unsigned LW     = 13;
  localparam int unsigned TRIG_W = 5;
  localparam int unsigned NTRIG  = 1 << TRIG_W;
  localparam int unsigned DESC_W = 2 * AW + LW + 19;

  typedef struct packed {
    logic [AW-1:0]     src;
    logic [AW-1:0]     dst;
    logic [LW-1:0]     len;
    logic [1:0]        src_step;
    logic [1:0]        dst_step;
    logic [1:0]        xmode;
    logic              word;
    logic [TRIG_W-1:0] trig;
    logic [2:0]        vlen;
    logic              m8;
    logic              irq_en;
    logic [1:0]        prio;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_RD, S_RDD, S_WR
  } state_t;
endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dma_pkg::*;
(
  input  logic [TRIG_W-1:0] sel_i,
  input  logic              sw_req_i,
  input  logic              prev_done_i,
  input  logic [NTRIG-1:0]  trig_i,
  output logic              hit_o
);
  always_comb begin
    unique case (sel_i)
      TRIG_W'(0): hit_o = sw_req_i;
      TRIG_W'(1): hit_o = prev_done_i;
      default:    hit_o = trig_i[sel_i];
    endcase
  end
endmodule

// File: rtl/dma_len_calc.sv
module dma_len_calc
  import dma_pkg::*;
(
  input  logic [7:0]    first_i,
  input  logic          m8_i,
  input  logic [2:0]    vlen_i,
  input  logic [LW-1:0] len_i,
  output logic          var_en_o,
  output logic [LW-1:0] total_o
);
  logic [7:0]    n;
  logic [1:0]    off;
  logic [LW-1:0] raw;

  assign n = m8_i ? {1'b0, first_i[6:0]} : first_i;

  always_comb begin
    var_en_o = 1'b1;
    unique case (vlen_i)
      3'd1:    off = 2'd1;
      3'd2:    off = 2'd0;
      3'd3:    off = 2'd2;
      3'd4:    off = 2'd3;
      default: begin off = 2'd0; var_en_o = 1'b0; end
    endcase
  end

  assign raw     = LW'(n) + LW'(off);
  assign total_o = (raw < len_i) ? raw : len_i;
endmodule

// File: rtl/dma_ptr_step.sv
module dma_ptr_step
  import dma_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    code_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] step;

  always_comb begin
    unique case (code_i)
      2'd0:    step = '0;
      2'd1:    step = AW'(1);
      2'd2:    step = AW'(2);
      default: step = '1;
    endcase
    addr_o = addr_i + (word_i ? (step << 1) : step);
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DESC_W-1:0] desc_i,
  input  logic              arm_we_i,
  input  logic [7:0]        arm_wdata_i,
  input  logic              sw_req_i,
  input  logic              prev_done_i,
  input  logic [NTRIG-1:0]  trig_i,
  input  logic              done_clr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              armed_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  desc_t         d_in, cfg_q;
  state_t        state_q;
  logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [LW-1:0] rem_q, cnt_cur, rem_nxt, var_total;
  logic [7:0]    data_q, fbyte_q;
  logic          first_q, beat_q, done_q, irq_q;
  logic          abort_w, arm_w, hit, var_en, unit_last, unit_fire;

  assign d_in    = desc_t'(desc_i);
  assign abort_w = arm_we_i & arm_wdata_i[7];
  assign arm_w   = arm_we_i & arm_wdata_i[0] & ~arm_wdata_i[7];

  dma_trig_sel u_trig (
    .sel_i(cfg_q.trig), .sw_req_i(sw_req_i), .prev_done_i(prev_done_i),
    .trig_i(trig_i), .hit_o(hit)
  );

  dma_len_calc u_len (
    .first_i(fbyte_q), .m8_i(cfg_q.m8), .vlen_i(cfg_q.vlen),
    .len_i(cfg_q.len), .var_en_o(var_en), .total_o(var_total)
  );

  dma_ptr_step u_src_step (
    .addr_i(src_q), .code_i(cfg_q.src_step), .word_i(cfg_q.word), .addr_o(src_nxt)
  );

  dma_ptr_step u_dst_step (
    .addr_i(dst_q), .code_i(cfg_q.dst_step), .word_i(cfg_q.word), .addr_o(dst_nxt)
  );

  assign unit_last = cfg_q.word ? beat_q : 1'b1;
  assign unit_fire = (state_q == S_WR) & mem_gnt_i & unit_last;
  assign cnt_cur   = (first_q && var_en) ? var_total : rem_q;
  assign rem_nxt   = (cnt_cur <= LW'(1)) ? '0 : cnt_cur - LW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      data_q  <= '0;
      fbyte_q <= '0;
      first_q <= 1'b0;
      beat_q  <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (done_clr_i) done_q <= 1'b0;
      if (abort_w) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (arm_w) begin
            cfg_q   <= d_in;
            src_q   <= d_in.src;
            dst_q   <= d_in.dst;
            rem_q   <= d_in.len;
            first_q <= 1'b1;
            state_q <= S_ARMED;
          end
          S_ARMED: if (hit) begin
            beat_q  <= 1'b0;
            state_q <= S_RD;
          end
          S_RD: if (mem_gnt_i) state_q <= S_RDD;
          S_RDD: begin
            data_q <= mem_rdata_i;
            if (first_q && !beat_q) fbyte_q <= mem_rdata_i;
            state_q <= S_WR;
          end
          S_WR: if (mem_gnt_i) begin
            if (!unit_last) begin
              beat_q  <= 1'b1;
              state_q <= S_RD;
            end else begin
              beat_q  <= 1'b0;
              first_q <= 1'b0;
              src_q   <= src_nxt;
              dst_q   <= dst_nxt;
              rem_q   <= rem_nxt;
              if (rem_nxt == '0) begin
                done_q <= 1'b1;
                irq_q  <= cfg_q.irq_en;
                if (cfg_q.xmode[1]) begin
                  src_q   <= cfg_q.src;
                  dst_q   <= cfg_q.dst;
                  rem_q   <= cfg_q.len;
                  first_q <= 1'b1;
                  state_q <= S_ARMED;
                end else begin
                  state_q <= S_IDLE;
                end
              end else begin
                state_q <= cfg_q.xmode[0] ? S_RD : S_ARMED;
              end
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req_o   = (state_q == S_RD) | (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = ((state_q == S_WR) ? dst_q : src_q) + AW'(beat_q);
  assign mem_wdata_o = data_q;
  assign armed_o     = (state_q != S_IDLE);
  assign busy_o      = (state_q == S_RD) | (state_q == S_RDD) | (state_q == S_WR);
  assign done_o      = done_q;
  assign irq_o       = irq_q;

  a_r9_abort_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> (!armed_o && !mem_req_o));

  a_r11_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !abort_w) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r10_irq_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);

  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cfg_q.irq_en);

  a_r2_idle_ignores_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !arm_w) |=> !busy_o);

  a_r8_count_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_fire && first_q && var_en) |-> (var_total <= cfg_q.len));
endmodule

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] desc = '0;
  logic        arm_we = 1'b0;
  logic [7:0]  arm_wdata = '0;
  logic        sw_req = 1'b0, prev_done = 1'b0, done_clr = 1'b0;
  logic [31:0] trig = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        armed, busy, done, irq;

  logic [7:0]  mem [256];
  logic [23:0] expq [$];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, irq_cnt = 0, cyc = 0;

  always #10 clk = ~clk;

  dma_chan_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .desc_i(desc), .arm_we_i(arm_we),
    .arm_wdata_i(arm_wdata), .sw_req_i(sw_req), .prev_done_i(prev_done),
    .trig_i(trig), .done_clr_i(done_clr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .armed_o(armed), .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes
  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (rst_n && mem_req && mem_we && mem_gnt) begin
      wr_cnt++;
      if (expq.size() == 0) chk(1'b0, "R12 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk({mem_addr, mem_wdata} == e, "R6/R7 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    while (cyc < 100000) @(negedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  function automatic logic [63:0] mk(input logic [15:0] s, d, input logic [12:0] len,
      input logic [1:0] ss, ds, xm, input logic w, input logic [4:0] tr,
      input logic [2:0] vl, input logic m8, ie);
    return {s, d, len, ss, ds, xm, w, tr, vl, m8, ie, 2'b00};
  endfunction

  function automatic logic [15:0] stepb(input logic [1:0] c, input logic w);
    logic [15:0] s;
    s = (c == 2'd0) ? 16'd0 : (c == 2'd1) ? 16'd1 : (c == 2'd2) ? 16'd2 : 16'hFFFF;
    return w ? (s << 1) : s;
  endfunction

  task automatic expect_copy(input logic [15:0] s, d, input int units, input logic w,
      input logic [1:0] ss, ds);
    for (int u = 0; u < units; u++) begin
      for (int b = 0; b < (w ? 2 : 1); b++)
        expq.push_back({d + 16'(b), mem[8'(s + 16'(b))]});
      s = s + stepb(ss, w);
      d = d + stepb(ds, w);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic arm(input logic [63:0] dsc);
    @(posedge clk); #2;
    desc = dsc; arm_we = 1'b1; arm_wdata = 8'h01;
    @(posedge clk); #2;
    arm_we = 1'b0;
  endtask

  task automatic abort();
    @(posedge clk); #2;
    arm_we = 1'b1; arm_wdata = 8'h80;
    @(posedge clk); #2;
    arm_we = 1'b0;
  endtask

  task automatic pulse_sw();
    @(posedge clk); #2; sw_req = 1'b1;
    @(posedge clk); #2; sw_req = 1'b0;
  endtask

  task automatic clr_done();
    @(posedge clk); #2; done_clr = 1'b1;
    @(posedge clk); #2; done_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    cycles(2);
  endtask

  initial begin
    int w0, i0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 255);
    cycles(3);
    @(negedge clk);
    chk(!armed && !busy && !done && !irq && !mem_req, "R13 reset state",
        {armed, busy, done, irq, mem_req}, 0);
    rst_n = 1'b1;
    cycles(2);

    // block, byte, software trigger
    arm(mk(16'h1010, 16'h2090, 13'd4, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd0, 1'b0, 1'b1));
    expect_copy(16'h1010, 16'h2090, 4, 1'b0, 2'd1, 2'd1);
    i0 = irq_cnt;
    pulse_sw();
    wait_idle();
    chk(expq.size() == 0, "R4 whole block on one trigger", expq.size(), 0);
    chk(done && !armed, "R4 done and disarmed", {done, armed}, 2'b10);
    chk(irq_cnt == i0 + 1, "R10 one irq pulse", irq_cnt - i0, 1);
    clr_done();
    @(negedge clk);
    chk(!done, "R10 done cleared", done, 0);

    // disarmed channel ignores triggers
    w0 = wr_cnt;
    pulse_sw();
    @(posedge clk); #2; trig = 32'hFFFF_FFFF; @(posedge clk); #2; trig = '0;
    cycles(10);
    chk(wr_cnt == w0 && !busy, "R2 trigger while disarmed ignored", wr_cnt - w0, 0);

    // single mode on event code 5
    arm(mk(16'h0020, 16'h00A0, 13'd3, 2'd1, 2'd1, 2'd0, 1'b0, 5'd5, 3'd0, 1'b0, 1'b0));
    w0 = wr_cnt;
    @(posedge clk); #2; trig[6] = 1'b1; @(posedge clk); #2; trig[6] = 1'b0;
    cycles(10);
    chk(wr_cnt == w0, "R2 other event line ignored", wr_cnt - w0, 0);
    expect_copy(16'h0020, 16'h00A0, 3, 1'b0, 2'd1, 2'd1);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2; trig[5] = 1'b1; @(posedge clk); #2; trig[5] = 1'b0;
      wait_idle();
      chk(wr_cnt == w0 + k + 1, "R3 one unit per trigger", wr_cnt - w0, k + 1);
      chk(armed == (k < 2), "R3 armed until count ends", armed, k < 2);
    end
    chk(done && expq.size() == 0, "R3 count complete", done, 1);
    i0 = irq_cnt;
    clr_done();

    // word mode, source -1 unit, destination +2 units
    arm(mk(16'h0040, 16'h00C0, 13'd2, 2'd3, 2'd2, 2'd1, 1'b1, 5'd0, 3'd0, 1'b0, 1'b0));
    expect_copy(16'h0040, 16'h00C0, 2, 1'b1, 2'd3, 2'd2);
    pulse_sw();
    wait_idle();
    chk(expq.size() == 0, "R6 word beats low byte first", expq.size(), 0);
    chk(irq_cnt == i0 && done, "R10 irq masked, done set", irq_cnt - i0, 0);
    clr_done();

    // byte mode, source held
    arm(mk(16'h0030, 16'h00B0, 13'd3, 2'd0, 2'd1, 2'd1, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0));
    expect_copy(16'h0030, 16'h00B0, 3, 1'b0, 2'd0, 2'd1);
    pulse_sw();
    wait_idle();
    chk(expq.size() == 0, "R7 hold step", expq.size(), 0);

    // variable count: mode 1, seven-bit, 0x82 -> 3 units
    mem[8'h50] = 8'h82;
    arm(mk(16'h0050, 16'h00D0, 13'd8, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd1, 1'b1, 1'b0));
    w0 = wr_cnt;
    expect_copy(16'h0050, 16'h00D0, 3, 1'b0, 2'd1, 2'd1);
    pulse_sw();
    wait_idle();
    chk(wr_cnt - w0 == 3, "R8 mode 1 seven-bit count", wr_cnt - w0, 3);

    // mode 3: 10+2 capped to length 5
    mem[8'h58] = 8'd10;
    arm(mk(16'h0058, 16'h00E8, 13'd5, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd3, 1'b0, 1'b0));
    w0 = wr_cnt;
    expect_copy(16'h0058, 16'h00E8, 5, 1'b0, 2'd1, 2'd1);
    pulse_sw();
    wait_idle();
    chk(wr_cnt - w0 == 5, "R8 count capped at length", wr_cnt - w0, 5);

    // mode 2: first byte 3 -> 3 units including itself
    mem[8'h60] = 8'd3;
    arm(mk(16'h0060, 16'h00F0, 13'd9, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd2, 1'b0, 1'b0));
    w0 = wr_cnt;
    expect_copy(16'h0060, 16'h00F0, 3, 1'b0, 2'd1, 2'd1);
    pulse_sw();
    wait_idle();
    chk(wr_cnt - w0 == 3, "R8 mode 2 count includes first byte", wr_cnt - w0, 3);
    clr_done();

    // repeated block on previous-channel trigger
    arm(mk(16'h0070, 16'h00E0, 13'd2, 2'd1, 2'd1, 2'd3, 1'b0, 5'd1, 3'd0, 1'b0, 1'b1));
    for (int k = 0; k < 2; k++) begin
      expect_copy(16'h0070, 16'h00E0, 2, 1'b0, 2'd1, 2'd1);
      @(posedge clk); #2; prev_done = 1'b1; @(posedge clk); #2; prev_done = 1'b0;
      wait_idle();
      chk(expq.size() == 0 && armed && done, "R5 reload and stay armed",
          {expq.size() == 0, armed, done}, 3'b111);
      clr_done();
    end
    abort();
    @(negedge clk);
    chk(!armed, "R9 abort disarms", armed, 0);

    // triggers during a block are dropped; request held while stalled
    arm(mk(16'h0010, 16'h0098, 13'd3, 2'd1, 2'd1, 2'd3, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0));
    mem_gnt = 1'b0;
    pulse_sw();
    pulse_sw();
    pulse_sw();
    @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == 16'h0010, "R11 request held without grant",
        mem_addr, 16'h0010);
    w0 = wr_cnt;
    expect_copy(16'h0010, 16'h0098, 3, 1'b0, 2'd1, 2'd1);
    @(posedge clk); #2; mem_gnt = 1'b1;
    wait_idle();
    cycles(30);
    chk(wr_cnt - w0 == 3, "R12 extra triggers not queued", wr_cnt - w0, 3);
    abort();
    clr_done();

    // abort mid-block while stalled
    arm(mk(16'h0020, 16'h00A8, 13'd4, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd0, 1'b0, 1'b1));
    mem_gnt = 1'b0;
    pulse_sw();
    cycles(3);
    abort();
    @(negedge clk);
    chk(!armed && !busy && !mem_req, "R9 abort ends request", {armed, busy, mem_req}, 0);
    w0 = wr_cnt;
    @(posedge clk); #2; mem_gnt = 1'b1;
    cycles(15);
    chk(wr_cnt == w0 && !done, "R9 no write or done after abort", wr_cnt - w0, 0);

    // abort and trigger in the same cycle
    arm(mk(16'h0020, 16'h00A8, 13'd4, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0));
    @(posedge clk); #2; arm_we = 1'b1; arm_wdata = 8'h81; sw_req = 1'b1;
    @(posedge clk); #2; arm_we = 1'b0; sw_req = 1'b0;
    @(negedge clk);
    chk(!armed && !mem_req, "R9 abort beats same-cycle trigger", {armed, mem_req}, 0);
    cycles(10);
    chk(wr_cnt == w0 && !done, "R9 nothing moved", wr_cnt - w0, 0);

    // re-arm while armed is ignored; zero length moves one unit
    arm(mk(16'h0011, 16'h00F8, 13'd0, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0));
    arm(mk(16'h0012, 16'h00FC, 13'd2, 2'd1, 2'd1, 2'd1, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0));
    w0 = wr_cnt;
    expect_copy(16'h0011, 16'h00F8, 1, 1'b0, 2'd1, 2'd1);
    pulse_sw();
    wait_idle();
    chk(wr_cnt - w0 == 1 && expq.size() == 0, "R1 second arm ignored, R4 zero len",
        wr_cnt - w0, 1);
    chk(done && !armed, "R4 zero length completes", {done, armed}, 2'b10);

    finish_run();
  end
endmodule